// File: doc/BRIEF.md
# Dual-Clock FIFO with Fall-Through Output Mode

This block is a first-in first-out buffer with independent write and read clocks. Words enter on the write clock and leave on the read clock. Pointers cross between the two clock domains as Gray code through two-stage synchronisers. Each clock domain computes its own flags from its own pointer and the synchronised copy of the other pointer.

Two timing modes are available, and the mode is captured while master reset is held. In standard mode a read enable fetches the next word into the output register one read clock later. The two status pins then mean "empty" and "full". In fall-through mode the oldest word is already on the output without any request, and a read enable consumes it. The two status pins then mean "output word valid" and "room for input". Because the output register holds one extra word, this mode stores one word more than the memory. That property lets several of these buffers be chained in depth with no extra logic.

A half-full flag and programmable almost-empty and almost-full flags work in both modes. Their thresholds and their timing style (clock-domain-local or live) are also captured during master reset. A partial reset empties the buffer but keeps the mode, the timing style and the thresholds.

Top module: `dcfifo_fwft`

## Requirements
- R1: While `mrst_n` is low both pointers return to the first location. After release, the flags read as follows. In standard mode `rd_flag`=1 and `wr_flag`=0. In fall-through mode `rd_flag`=0 and `wr_flag`=1. In both modes `almost_empty`=1, `almost_full`=0 and `half_full`=0.
- R2: `cfg_fwft`, `cfg_flag_async`, `cfg_ae_off` and `cfg_af_off` are sampled only on write clock edges while `mrst_n` is low. Changing them afterwards has no effect.
- R3: In standard mode (`cfg_fwft`=0), a read enable seen at a rising read clock edge while the buffer is not empty loads the oldest word into `rdata` at that edge. Words leave in write order. Without a read enable, `rdata` holds its value.
- R4: In fall-through mode (`cfg_fwft`=1), the oldest word appears on `rdata` with `rd_flag`=1 without any read enable. A read enable at a rising read clock edge consumes that word and presents the next one, or clears `rd_flag` if no word is left.
- R5: With DEPTH = 2^AW, standard mode sets `wr_flag`=1 after DEPTH words are stored. Fall-through mode clears `wr_flag` only after DEPTH+1 words are stored.
- R6: A write presented while the memory is full is dropped. The stored contents and the write pointer do not change.
- R7: A read enable while empty does not change `rdata` or the read pointer. A later write and read still return the correct word.
- R8: `half_full` is 1 when the memory holds more than DEPTH/2 words, as seen in the write clock domain.
- R9: `almost_empty` is 1 when the occupancy is at or below `cfg_ae_off`. The occupancy counts the memory words plus the fall-through output word.
- R10: `almost_full` is 1 when the free memory locations are at or below `cfg_af_off`.
- R11: With `cfg_flag_async`=0, `almost_empty` follows the read-domain view and `almost_full` follows the write-domain view, so each lags the other clock by the synchroniser. With `cfg_flag_async`=1, both flags come from the live pointers. A write therefore clears `almost_empty` right after the write clock edge that stores it.
- R12: Taking `prst_n` low empties the buffer. The captured mode, timing style and thresholds stay in effect, even if the configuration inputs have changed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Write clock |
| rclk | input | 1 | Read clock |
| mrst_n | input | 1 | Master reset, active low; configuration is captured while low |
| prst_n | input | 1 | Partial reset, active low; clears pointers only |
| cfg_fwft | input | 1 | Mode select: 1 selects fall-through mode |
| cfg_flag_async | input | 1 | Almost-flag timing: 1 selects live pointers |
| cfg_ae_off | input | AW+1 | Almost-empty threshold |
| cfg_af_off | input | AW+1 | Almost-full threshold |
| wr_en | input | 1 | Write request |
| wdata | input | DW | Write data |
| rd_en | input | 1 | Read request |
| rdata | output | DW | Read data |
| rd_flag | output | 1 | Standard mode: empty; fall-through mode: output word valid |
| wr_flag | output | 1 | Standard mode: full; fall-through mode: room for input |
| half_full | output | 1 | More than half the memory used |
| almost_empty | output | 1 | Occupancy at or below threshold |
| almost_full | output | 1 | Free space at or below threshold |

## Verification
Internal state faults show up mostly through the data order and the flags. A corrupted write pointer shows as a lost or repeated word on the next read. A broken synchroniser or Gray encoding leaves `rd_flag` or `wr_flag` wrong after the few read clock cycles that a crossing needs. A broken fall-through stage shows as a missing first word, or as a full flag one word early. A partial reset that disturbs the captured configuration shows at once as the wrong flag polarity or the wrong threshold on the next write.

// File: rtl/dcfifo_fwft.sv
module dcfifo_fwft #(
  parameter int DW = 8,
  parameter int AW = 4
) (
  input  logic          wclk,
  input  logic          rclk,
  input  logic          mrst_n,
  input  logic          prst_n,
  input  logic          cfg_fwft,
  input  logic          cfg_flag_async,
  input  logic [AW:0]   cfg_ae_off,
  input  logic [AW:0]   cfg_af_off,
  input  logic          wr_en,
  input  logic [DW-1:0] wdata,
  input  logic          rd_en,
  output logic [DW-1:0] rdata,
  output logic          rd_flag,
  output logic          wr_flag,
  output logic          half_full,
  output logic          almost_empty,
  output logic          almost_full
);
  localparam int DEPTH = 1 << AW;
  localparam int CW = AW + 1;

  function automatic logic [CW-1:0] gray2bin(input logic [CW-1:0] g);
    logic [CW-1:0] b;
    b = '0;
    for (int i = 0; i < CW; i++) b = b ^ (g >> i);
    return b;
  endfunction

  logic [DW-1:0] mem [DEPTH];

  logic          fwft_q, async_q;
  logic [CW-1:0] ae_q, af_q;

  always_ff @(posedge wclk)
    if (!mrst_n) begin
      fwft_q  <= cfg_fwft;
      async_q <= cfg_flag_async;
      ae_q    <= cfg_ae_off;
      af_q    <= cfg_af_off;
    end

  wire rst_n = mrst_n & prst_n;

  logic [CW-1:0] wbin, wgray, rg_s1, rg_s2;
  logic [CW-1:0] rbin, rgray, wg_s1, wg_s2;
  logic          ov;

  wire [CW-1:0] rbin_w = gray2bin(rg_s2);
  wire [CW-1:0] w_cnt  = wbin - rbin_w;
  wire          w_full = (w_cnt == CW'(DEPTH));
  wire          w_push = wr_en & ~w_full;
  wire [CW-1:0] wbin_n = wbin + CW'(1);

  always_ff @(posedge wclk or negedge rst_n)
    if (!rst_n) begin
      wbin  <= '0;
      wgray <= '0;
      rg_s1 <= '0;
      rg_s2 <= '0;
    end else begin
      rg_s1 <= rgray;
      rg_s2 <= rg_s1;
      if (w_push) begin
        wbin  <= wbin_n;
        wgray <= wbin_n ^ (wbin_n >> 1);
      end
    end

  always_ff @(posedge wclk)
    if (w_push) mem[wbin[AW-1:0]] <= wdata;

  wire [CW-1:0] wbin_r    = gray2bin(wg_s2);
  wire [CW-1:0] r_cnt     = wbin_r - rbin;
  wire          mem_empty = (r_cnt == '0);
  wire          r_pop     = ~mem_empty & (fwft_q ? (~ov | rd_en) : rd_en);
  wire [CW-1:0] rbin_n    = rbin + CW'(1);

  always_ff @(posedge rclk or negedge rst_n)
    if (!rst_n) begin
      rbin  <= '0;
      rgray <= '0;
      wg_s1 <= '0;
      wg_s2 <= '0;
      ov    <= 1'b0;
      rdata <= '0;
    end else begin
      wg_s1 <= wgray;
      wg_s2 <= wg_s1;
      if (r_pop) begin
        rbin  <= rbin_n;
        rgray <= rbin_n ^ (rbin_n >> 1);
        rdata <= mem[rbin[AW-1:0]];
      end
      if (fwft_q) begin
        if (r_pop) ov <= 1'b1;
        else if (rd_en) ov <= 1'b0;
      end else ov <= 1'b0;
    end

  wire [CW-1:0] live_cnt = wbin - rbin;
  wire [CW:0]   occ_sync = {1'b0, r_cnt} + {{CW{1'b0}}, ov};
  wire [CW:0]   occ_live = {1'b0, live_cnt} + {{CW{1'b0}}, ov};
  wire [CW-1:0] free_w   = CW'(DEPTH) - w_cnt;
  wire [CW-1:0] free_l   = CW'(DEPTH) - live_cnt;

  assign rd_flag      = fwft_q ? ov : mem_empty;
  assign wr_flag      = fwft_q ? ~w_full : w_full;
  assign half_full    = (w_cnt > CW'(DEPTH / 2));
  assign almost_empty = (async_q ? occ_live : occ_sync) <= {1'b0, ae_q};
  assign almost_full  = (async_q ? free_l : free_w) <= af_q;
endmodule

// File: rtl/dcfifo_fwft_chk.sv
module dcfifo_fwft_chk #(
  parameter int DW = 8,
  parameter int AW = 4
) (
  input logic          wclk,
  input logic          rclk,
  input logic          rst_n,
  input logic          fwft_q,
  input logic          wr_en,
  input logic          rd_en,
  input logic          w_full,
  input logic          mem_empty,
  input logic          ov,
  input logic [AW:0]   wbin,
  input logic [AW:0]   rbin,
  input logic [AW:0]   w_cnt,
  input logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  AST_NO_OVERFLOW: assert property (@(posedge wclk) disable iff (!rst_n)
    (w_full && wr_en) |=> $stable(wbin)); // R6
  AST_NO_UNDERFLOW: assert property (@(posedge rclk) disable iff (!rst_n)
    (mem_empty && rd_en) |=> $stable(rbin)); // R7
  AST_OCC_BOUND: assert property (@(posedge wclk) disable iff (!rst_n)
    w_cnt <= (AW+1)'(DEPTH)); // R5
  AST_STD_HOLD: assert property (@(posedge rclk) disable iff (!rst_n)
    (!fwft_q && !rd_en) |=> $stable(rdata)); // R3
  AST_FWFT_HOLD: assert property (@(posedge rclk) disable iff (!rst_n)
    (fwft_q && ov && !rd_en) |=> (ov && $stable(rdata))); // R4
endmodule

bind dcfifo_fwft dcfifo_fwft_chk #(.DW(DW), .AW(AW)) u_chk (
  .wclk(wclk), .rclk(rclk), .rst_n(rst_n), .fwft_q(fwft_q),
  .wr_en(wr_en), .rd_en(rd_en), .w_full(w_full), .mem_empty(mem_empty),
  .ov(ov), .wbin(wbin), .rbin(rbin), .w_cnt(w_cnt), .rdata(rdata)
);

// File: tb/sim_dcfifo_fwft.sv
module sim_dcfifo_fwft;
  localparam int DW = 8, AW = 4, DEPTH = 16;

  logic wclk = 0, rclk = 0;
  logic mrst_n = 0, prst_n = 1;
  logic cfg_fwft = 0, cfg_flag_async = 0;
  logic [AW:0] cfg_ae_off = 0, cfg_af_off = 0;
  logic wr_en = 0, rd_en = 0;
  logic [DW-1:0] wdata = 0;
  logic [DW-1:0] rdata;
  logic rd_flag, wr_flag, half_full, almost_empty, almost_full;

  int nchk = 0, nerr = 0;
  bit done = 0;

  always #4 wclk = ~wclk;
  always #5 rclk = ~rclk;

  dcfifo_fwft #(.DW(DW), .AW(AW)) u0 (.*);

  // {data, expected almost_empty, half_full, almost_full} after each write; thresholds ae=2, af=3
  localparam logic [10:0] VEC [16] = '{
    {8'h11,3'b100}, {8'h22,3'b100}, {8'h33,3'b000}, {8'h44,3'b000},
    {8'h55,3'b000}, {8'h66,3'b000}, {8'h77,3'b000}, {8'h88,3'b000},
    {8'h99,3'b010}, {8'hAA,3'b010}, {8'hBB,3'b010}, {8'hCC,3'b010},
    {8'hDD,3'b011}, {8'hEE,3'b011}, {8'hF0,3'b011}, {8'h0F,3'b011}};

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic settle();
    repeat (6) @(negedge rclk);
    repeat (2) @(negedge wclk);
  endtask

  task automatic mreset(input logic fw, input logic as, input int ae, input int af);
    cfg_fwft = fw; cfg_flag_async = as;
    cfg_ae_off = (AW+1)'(ae); cfg_af_off = (AW+1)'(af);
    mrst_n = 0;
    repeat (3) @(negedge wclk);
    mrst_n = 1;
    settle();
  endtask

  task automatic wr(input logic [DW-1:0] d);
    @(negedge wclk); wr_en = 1; wdata = d;
    @(negedge wclk); wr_en = 0;
  endtask

  task automatic rd();
    @(negedge rclk); rd_en = 1;
    @(negedge rclk); rd_en = 0;
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      nerr++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
      $finish;
    end
  end

  initial begin
    // Standard mode, synchronous almost flags
    mreset(0, 0, 2, 3);
    chk("R1 std rd_flag", rd_flag, 1);
    chk("R1 std wr_flag", wr_flag, 0);
    chk("R1 almost_empty", almost_empty, 1);
    chk("R1 almost_full", almost_full, 0);
    chk("R1 half_full", half_full, 0);

    for (int k = 0; k < 16; k++) begin
      wr(VEC[k][10:3]);
      settle();
      chk("R9 almost_empty", almost_empty, VEC[k][2]);
      chk("R8 half_full", half_full, VEC[k][1]);
      chk("R10 almost_full", almost_full, VEC[k][0]);
    end
    chk("R5 std full", wr_flag, 1);
    chk("R3 not empty", rd_flag, 0);
    wr(8'h5E);
    settle();
    chk("R6 still full", wr_flag, 1);

    for (int k = 0; k < 16; k++) begin
      rd();
      chk("R3 read order", rdata, VEC[k][10:3]);
    end
    settle();
    chk("R3 rdata held", rdata, 8'h0F);
    chk("R6 dropped word absent, empty", rd_flag, 1);
    rd();
    settle();
    chk("R7 read while empty", rdata, 8'h0F);
    wr(8'h5A);
    settle();
    rd();
    chk("R7 later read", rdata, 8'h5A);

    // Fall-through mode
    mreset(1, 0, 1, 1);
    chk("R1 fwft rd_flag", rd_flag, 0);
    chk("R1 fwft wr_flag", wr_flag, 1);
    chk("R1 fwft almost_empty", almost_empty, 1);
    wr(8'hA5);
    settle();
    chk("R4 first word valid", rd_flag, 1);
    chk("R4 first word data", rdata, 8'hA5);
    chk("R9 fwft one word", almost_empty, 1);
    wr(8'h3C);
    settle();
    chk("R9 fwft two words", almost_empty, 0);
    chk("R4 output held", rdata, 8'hA5);
    rd();
    settle();
    chk("R4 next word", rdata, 8'h3C);
    rd();
    settle();
    chk("R4 drained", rd_flag, 0);

    begin
      int n;
      n = 0;
      while (wr_flag && n < 40) begin
        wr(8'(n + 1));
        settle();
        n++;
      end
      chk("R5 fwft capacity", n, DEPTH + 1);
      chk("R10 fwft almost_full", almost_full, 1);
      for (int i = 0; i < DEPTH + 1; i++) begin
        chk("R4 fwft valid", rd_flag, 1);
        chk("R4 fwft order", rdata, 8'(i + 1));
        rd();
        settle();
      end
      chk("R4 fwft empty", rd_flag, 0);
    end

    // Live almost flags
    mreset(0, 1, 0, 0);
    @(negedge wclk); wr_en = 1; wdata = 8'h77;
    @(posedge wclk); #1;
    chk("R11 live almost_empty", almost_empty, 0);
    @(negedge wclk); wr_en = 0;
    settle();

    // Synchronous almost flags lag the write clock
    mreset(0, 0, 0, 0);
    @(negedge wclk); wr_en = 1; wdata = 8'h78;
    @(posedge wclk); #1;
    chk("R11 sync almost_empty lags", almost_empty, 1);
    @(negedge wclk); wr_en = 0;
    settle();
    chk("R11 sync almost_empty settles", almost_empty, 0);

    // Partial reset keeps configuration
    mreset(0, 0, 2, 3);
    for (int k = 0; k < 5; k++) wr(8'(k));
    settle();
    cfg_fwft = 1; cfg_ae_off = 0; cfg_af_off = 0;
    settle();
    @(negedge wclk); prst_n = 0;
    repeat (3) @(negedge wclk);
    prst_n = 1;
    settle();
    chk("R12 emptied std polarity", rd_flag, 1);
    chk("R12 not full", wr_flag, 0);
    chk("R2 mode kept", rd_flag, 1);
    wr(8'hC1);
    wr(8'hC2);
    settle();
    chk("R12 ae offset kept", almost_empty, 1);
    chk("R2 std read needed", rdata, 8'h00);
    rd();
    chk("R12 data after partial reset", rdata, 8'hC1);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end
endmodule